// File: doc/BRIEF.md
# Coprocessor Run and Context Controller

This block is the register face of a reconfigurable compute engine toward a host processor. The host loads configuration images for any of several physical contexts through a word-wide configuration port. It picks which context the engine uses by writing a context register. It then starts the engine by writing a cycle budget. The engine's run-enable stays high for exactly that many clocks while the budget counts down, and the host can read the remaining budget at any time.

The configuration store keeps one image per context. Each image is a fixed number of 32-bit words with the unused top bits of the last word forced to zero. The engine reads words of the active context by index. Configuration writes pass through a short ordered queue. A word aimed at the context that is running waits in the queue until the run ends. Words for other contexts go straight through. A small arbiter settles host/engine collisions on the two stream FIFOs in favour of the engine.

Top module: `cop_run_ctrl`

## Requirements
- R1: After reset, eng_run is low, eng_ctx is 0, eng_ctx_switch is low and a read of the status register (address 2) returns 0.
- R2: A host write of a nonzero value N to the count register (address 0) while idle raises eng_run in the next cycle and keeps it high for exactly N consecutive cycles.
- R3: A read of the count register returns, one cycle after the read request, the budget remaining in the cycle the request was sampled; the budget drops by one in every cycle eng_run is high.
- R4: A count write while eng_run is high is ignored, and a write of zero while idle leaves eng_run low.
- R5: A write to the context register (address 1, low CTX_W bits) while idle updates eng_ctx in the next cycle. eng_ctx_switch pulses high for that one cycle only when the value changes. Reading address 1 returns the active context.
- R6: A context write while eng_run is high is rejected: eng_ctx keeps its value, no switch pulse is issued, and status bit 1 is set.
- R7: Each context holds WORDS 32-bit words (29 for 918 bits); bits 31:22 of word 28 are stored as zero. Any word of any context may be rewritten alone. eng_cfg_word shows word eng_cfg_idx of the active context one cycle after the index is presented.
- R8: A configuration write with a word offset of WORDS or more is ignored and alters no stored word. A read index of WORDS or more returns 0.
- R9: A configuration write to the active context while eng_run is high is held until the run ends, and the stored word keeps its old value meanwhile. Status bit 3 is high while any configuration write is held.
- R10: A configuration write that arrives while PEND_DEPTH writes are held is dropped and sets status bit 2.
- R11: Status bit 0 mirrors eng_run. Writing the status register clears bit 1 and bit 2 wherever the written data has a one.
- R12: For each FIFO port, an engine request is always granted. A host request is granted only when the engine does not request the same port in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_addr | input | 2 | Register select: 0 count, 1 context, 2 status |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Registered read data |
| cfg_wr_en | input | 1 | Configuration word write strobe |
| cfg_ctx | input | CTX_W | Target context of the configuration word |
| cfg_ofs | input | OFS_W | Word offset within the context |
| cfg_wdata | input | DW | Configuration word |
| eng_run | output | 1 | Engine run-enable |
| eng_ctx | output | CTX_W | Active context |
| eng_ctx_switch | output | 1 | One-cycle pulse on a context change |
| eng_cfg_idx | input | OFS_W | Configuration word index requested by the engine |
| eng_cfg_word | output | DW | Requested word of the active context |
| host_fifo_req | input | 2 | Host access requests, one per FIFO |
| eng_fifo_req | input | 2 | Engine access requests, one per FIFO |
| host_fifo_gnt | output | 2 | Host access grants |
| eng_fifo_gnt | output | 2 | Engine access grants |

## Verification
The bench measures the run length and reads the budget mid-run at a known cycle. An off-by-one in the countdown shows up there as a run of N±1 or a read that is one too high. It tries to reselect a context and to reload the budget in the middle of a run. A controller that accepted either would move eng_ctx or stretch the run. It rewrites the active context while running and checks that the old word is still served and is replaced only after the run. It also overfills the hold queue, aliases an out-of-range offset onto the next context's first word, and checks the zeroed top of the last word. A design without deferral, bounds checks or padding would return a changed word in one of these cases.

// File: rtl/cop_pkg.sv
package cop_pkg;
  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_CTX    = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

  localparam int ST_RUN      = 0;
  localparam int ST_SEL_REJ  = 1;
  localparam int ST_CFG_DROP = 2;
  localparam int ST_CFG_PEND = 3;

  localparam int N_FIFO = 2;

  function automatic int words_for(input int bits, input int w);
    return (bits + w - 1) / w;
  endfunction
endpackage

// File: rtl/cop_run_meter.sv
module cop_run_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             running,
  output logic [CNT_W-1:0] remaining
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    else if (load)         cnt_q <= load_val;
  end

  assign running   = (cnt_q != '0);
  assign remaining = cnt_q;
endmodule

// File: rtl/cop_cfg_queue.sv
module cop_cfg_queue #(
  parameter int ENTRY_W = 40,
  parameter int DEPTH   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_data,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head,
  output logic               not_empty,
  output logic               full
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

  logic [ENTRY_W-1:0] slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW:0]   cnt;
  logic do_push, do_pop;

  assign full      = (cnt == FULL_CNT);
  assign not_empty = (cnt != '0);
  assign do_push   = push && !full;
  assign do_pop    = pop && not_empty;
  assign head      = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/cop_cfg_store.sv
module cop_cfg_store #(
  parameter int NUM_CTX = 4,
  parameter int WORDS   = 29,
  parameter int CTX_W   = 2,
  parameter int OFS_W   = 5,
  parameter int DW      = 32
) (
  input  logic             clk,
  input  logic             we,
  input  logic [CTX_W-1:0] wctx,
  input  logic [OFS_W-1:0] wofs,
  input  logic [DW-1:0]    wdata,
  input  logic [CTX_W-1:0] rctx,
  input  logic [OFS_W-1:0] rofs,
  output logic [DW-1:0]    rdata
);
  localparam int ENTRIES = NUM_CTX * WORDS;
  localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [DW-1:0] ram [ENTRIES];
  logic [AW-1:0] waddr, raddr;
  logic          rd_ok, rd_ok_q;
  logic [DW-1:0] rd_q;

  assign waddr = AW'(int'(wctx) * WORDS + int'(wofs));
  assign rd_ok = (int'(rofs) < WORDS);
  assign raddr = rd_ok ? AW'(int'(rctx) * WORDS + int'(rofs)) : '0;

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rd_q    <= ram[raddr];
    rd_ok_q <= rd_ok;
  end

  assign rdata = rd_ok_q ? rd_q : '0;
endmodule

// File: rtl/cop_fifo_arb.sv
module cop_fifo_arb #(
  parameter int PORTS = 2
) (
  input  logic [PORTS-1:0] host_req,
  input  logic [PORTS-1:0] eng_req,
  output logic [PORTS-1:0] host_gnt,
  output logic [PORTS-1:0] eng_gnt
);
  for (genvar i = 0; i < PORTS; i++) begin : g_port
    assign eng_gnt[i]  = eng_req[i];
    assign host_gnt[i] = host_req[i] & ~eng_req[i];
  end
endmodule

// File: rtl/cop_run_ctrl.sv
module cop_run_ctrl #(
  parameter int NUM_CTX    = 4,
  parameter int CFG_BITS   = 918,
  parameter int DW         = 32,
  parameter int CNT_W      = 16,
  parameter int PEND_DEPTH = 4,
  parameter int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  parameter int OFS_W      = $clog2((CFG_BITS + DW - 1) / DW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr_en,
  input  logic             host_rd_en,
  input  logic [1:0]       host_addr,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  input  logic             cfg_wr_en,
  input  logic [CTX_W-1:0] cfg_ctx,
  input  logic [OFS_W-1:0] cfg_ofs,
  input  logic [DW-1:0]    cfg_wdata,
  output logic             eng_run,
  output logic [CTX_W-1:0] eng_ctx,
  output logic             eng_ctx_switch,
  input  logic [OFS_W-1:0] eng_cfg_idx,
  output logic [DW-1:0]    eng_cfg_word,
  input  logic [1:0]       host_fifo_req,
  input  logic [1:0]       eng_fifo_req,
  output logic [1:0]       host_fifo_gnt,
  output logic [1:0]       eng_fifo_gnt
);
  import cop_pkg::*;

  localparam int WORDS     = words_for(CFG_BITS, DW);
  localparam int LAST_BITS = CFG_BITS - (WORDS - 1) * DW;
  localparam logic [DW-1:0] LAST_MASK = DW'((64'd1 << LAST_BITS) - 64'd1);
  localparam int ENTRY_W   = CTX_W + OFS_W + DW;

  logic             running;
  logic [CNT_W-1:0] remaining;
  logic [CTX_W-1:0] active_q;
  logic             switch_q, sel_rej_q, cfg_drop_q;
  logic [DW-1:0]    rdata_q;

  logic count_wr, ctx_wr, stat_wr;
  assign count_wr = host_wr_en && (host_addr == ADDR_COUNT);
  assign ctx_wr   = host_wr_en && (host_addr == ADDR_CTX);
  assign stat_wr  = host_wr_en && (host_addr == ADDR_STATUS);

  cop_run_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst(rst),
    .load(count_wr && !running),
    .load_val(host_wdata[CNT_W-1:0]),
    .running(running), .remaining(remaining)
  );

  // configuration write path: range check, padding, ordered hold queue
  logic               cfg_ok, q_full, q_valid, q_pop;
  logic [DW-1:0]      cfg_masked;
  logic [ENTRY_W-1:0] q_head;
  logic [CTX_W-1:0]   head_ctx;
  logic [OFS_W-1:0]   head_ofs;
  logic [DW-1:0]      head_data;

  assign cfg_ok     = cfg_wr_en && (int'(cfg_ofs) < WORDS) && (int'(cfg_ctx) < NUM_CTX);
  assign cfg_masked = (int'(cfg_ofs) == WORDS - 1) ? (cfg_wdata & LAST_MASK) : cfg_wdata;
  assign {head_ctx, head_ofs, head_data} = q_head;
  assign q_pop = q_valid && (!running || head_ctx != active_q);

  cop_cfg_queue #(.ENTRY_W(ENTRY_W), .DEPTH(PEND_DEPTH)) u_queue (
    .clk(clk), .rst(rst),
    .push(cfg_ok), .push_data({cfg_ctx, cfg_ofs, cfg_masked}),
    .pop(q_pop), .head(q_head), .not_empty(q_valid), .full(q_full)
  );

  cop_cfg_store #(.NUM_CTX(NUM_CTX), .WORDS(WORDS), .CTX_W(CTX_W),
                  .OFS_W(OFS_W), .DW(DW)) u_store (
    .clk(clk), .we(q_pop), .wctx(head_ctx), .wofs(head_ofs), .wdata(head_data),
    .rctx(active_q), .rofs(eng_cfg_idx), .rdata(eng_cfg_word)
  );

  cop_fifo_arb #(.PORTS(N_FIFO)) u_arb (
    .host_req(host_fifo_req), .eng_req(eng_fifo_req),
    .host_gnt(host_fifo_gnt), .eng_gnt(eng_fifo_gnt)
  );

  logic [CTX_W-1:0] sel_val;
  logic [DW-1:0]    status;
  assign sel_val = host_wdata[CTX_W-1:0];
  always_comb begin
    status = '0;
    status[ST_RUN]      = running;
    status[ST_SEL_REJ]  = sel_rej_q;
    status[ST_CFG_DROP] = cfg_drop_q;
    status[ST_CFG_PEND] = q_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= '0;
      switch_q   <= 1'b0;
      sel_rej_q  <= 1'b0;
      cfg_drop_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      switch_q <= 1'b0;
      if (ctx_wr && !running && int'(sel_val) < NUM_CTX) begin
        active_q <= sel_val;
        switch_q <= (sel_val != active_q);
      end
      if (stat_wr && host_wdata[ST_SEL_REJ])  sel_rej_q  <= 1'b0;
      if (stat_wr && host_wdata[ST_CFG_DROP]) cfg_drop_q <= 1'b0;
      if (ctx_wr && running)                  sel_rej_q  <= 1'b1;
      if (cfg_ok && q_full)                   cfg_drop_q <= 1'b1;
      if (host_rd_en) begin
        case (host_addr)
          ADDR_COUNT:  rdata_q <= DW'(remaining);
          ADDR_CTX:    rdata_q <= DW'(active_q);
          ADDR_STATUS: rdata_q <= status;
          default:     rdata_q <= '0;
        endcase
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^host_wdata;

  assign host_rdata     = rdata_q;
  assign eng_run        = running;
  assign eng_ctx        = active_q;
  assign eng_ctx_switch = switch_q;
endmodule

// File: rtl/cop_run_ctrl_chk.sv
module cop_run_ctrl_chk #(
  parameter int CTX_W = 2,
  parameter int CNT_W = 16,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             host_wr_en,
  input logic [1:0]       host_addr,
  input logic [DW-1:0]    host_wdata,
  input logic             eng_run,
  input logic [CTX_W-1:0] eng_ctx,
  input logic             eng_ctx_switch,
  input logic [CNT_W-1:0] remaining,
  input logic             store_we,
  input logic [CTX_W-1:0] store_ctx,
  input logic [1:0]       host_fifo_req,
  input logic [1:0]       eng_fifo_req,
  input logic [1:0]       host_fifo_gnt,
  input logic [1:0]       eng_fifo_gnt
);
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && host_addr == 2'd0 && !eng_run && host_wdata[CNT_W-1:0] != '0)
    |=> (eng_run && remaining == $past(host_wdata[CNT_W-1:0])));

  assert_countdown_R3: assert property (@(posedge clk) disable iff (rst)
    eng_run |=> (remaining == CNT_W'($past(remaining) - 1'b1)));

  assert_stop_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(eng_run) |-> (remaining == '0 && $past(remaining) == CNT_W'(1)));

  assert_switch_change_R5: assert property (@(posedge clk) disable iff (rst)
    eng_ctx_switch |-> (eng_ctx != $past(eng_ctx) && !eng_run));

  assert_ctx_hold_R6: assert property (@(posedge clk) disable iff (rst)
    eng_run |=> $stable(eng_ctx));

  assert_defer_R9: assert property (@(posedge clk) disable iff (rst)
    (store_we && eng_run) |-> (store_ctx != eng_ctx));

  assert_arb_R12: assert property (@(posedge clk) disable iff (rst)
    ((host_fifo_gnt & eng_fifo_gnt) == 2'b00) && ((eng_fifo_gnt ^ eng_fifo_req) == 2'b00)
    && ((host_fifo_gnt & ~host_fifo_req) == 2'b00));
endmodule

bind cop_run_ctrl cop_run_ctrl_chk #(.CTX_W(CTX_W), .CNT_W(CNT_W), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_addr(host_addr),
  .host_wdata(host_wdata), .eng_run(eng_run), .eng_ctx(eng_ctx),
  .eng_ctx_switch(eng_ctx_switch), .remaining(remaining),
  .store_we(q_pop), .store_ctx(head_ctx),
  .host_fifo_req(host_fifo_req), .eng_fifo_req(eng_fifo_req),
  .host_fifo_gnt(host_fifo_gnt), .eng_fifo_gnt(eng_fifo_gnt)
);

// File: tb/cop_run_ctrl_test.sv
`timescale 1ns/1ps
module cop_run_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_ctx = '0;
  logic [4:0]  cfg_ofs = '0;
  logic [31:0] cfg_wdata = '0;
  logic        eng_run, eng_ctx_switch;
  logic [1:0]  eng_ctx;
  logic [4:0]  eng_cfg_idx = '0;
  logic [31:0] eng_cfg_word;
  logic [1:0]  host_fifo_req = '0, eng_fifo_req = '0, host_fifo_gnt, eng_fifo_gnt;

  always #2.5 clk = ~clk;

  cop_run_ctrl uut (.*);

  typedef struct { string req; logic [31:0] val; } exp_t;
  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic expect_item(input string r, input logic [31:0] v);
    exp_t e; e.req = r; e.val = v; exp_q.push_back(e);
  endtask

  task automatic monitor_pop(input logic [31:0] act);
    exp_t e = exp_q.pop_front();
    n_cmp++;
    if (act !== e.val) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", e.req, act, e.val);
    end
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    expect_item(r, exp);
    monitor_pop(act);
  endtask

  task automatic host_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr_en = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); host_rd_en = 1'b1; host_addr = a;
    @(negedge clk); host_rd_en = 1'b0; v = host_rdata;
  endtask

  task automatic cfg_write(input logic [1:0] c, input logic [4:0] o, input logic [31:0] d);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_ctx = c; cfg_ofs = o; cfg_wdata = d;
    @(negedge clk); cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_read(input logic [4:0] i, output logic [31:0] v);
    @(negedge clk); eng_cfg_idx = i;
    @(negedge clk); v = eng_cfg_word;
  endtask

  task automatic wait_idle();
    while (eng_run) @(negedge clk);
  endtask

  function automatic logic [31:0] img1(input int w);
    return (w == 28) ? 32'h003F_FFFF : (32'hA500_0000 | 32'(w));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int len;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 run", 32'(eng_run), 0);
    chk("R1 ctx", 32'(eng_ctx), 0);
    chk("R1 switch", 32'(eng_ctx_switch), 0);
    host_read(2'd2, v); chk("R1 status", v, 0);

    // R12 FIFO arbitration
    @(negedge clk); host_fifo_req = 2'b11; eng_fifo_req = 2'b01; #1;
    chk("R12 host gnt", 32'(host_fifo_gnt), 32'b10);
    chk("R12 eng gnt", 32'(eng_fifo_gnt), 32'b01);
    @(negedge clk); eng_fifo_req = 2'b00; #1;
    chk("R12 host alone", 32'(host_fifo_gnt), 32'b11);
    @(negedge clk); host_fifo_req = 2'b01; eng_fifo_req = 2'b10; #1;
    chk("R12 split host", 32'(host_fifo_gnt), 32'b01);
    chk("R12 split eng", 32'(eng_fifo_gnt), 32'b10);
    @(negedge clk); host_fifo_req = '0; eng_fifo_req = '0;

    // R5 context select while idle
    host_write(2'd1, 32'd1);
    chk("R5 ctx", 32'(eng_ctx), 1);
    chk("R5 pulse", 32'(eng_ctx_switch), 1);
    @(negedge clk); chk("R5 pulse one cycle", 32'(eng_ctx_switch), 0);
    host_write(2'd1, 32'd1);
    chk("R5 same ctx no pulse", 32'(eng_ctx_switch), 0);
    host_read(2'd1, v); chk("R5 readback", v, 1);

    // R7 full load of context 1, padding, partial rewrite
    for (int w = 0; w < 29; w++)
      cfg_write(2'd1, 5'(w), (w == 28) ? 32'hFFFF_FFFF : (32'hA500_0000 | 32'(w)));
    repeat (3) @(negedge clk);
    for (int w = 0; w < 29; w++) begin
      cfg_read(5'(w), v); chk("R7 full image", v, img1(w));
    end
    cfg_write(2'd1, 5'd5, 32'h1234_5678);
    repeat (3) @(negedge clk);
    cfg_read(5'd5, v); chk("R7 partial word", v, 32'h1234_5678);
    cfg_read(5'd6, v); chk("R7 neighbour kept", v, img1(6));

    // R8 out-of-range offsets
    cfg_write(2'd2, 5'd0, 32'hCAFE_0002);
    cfg_write(2'd2, 5'd5, 32'h5555_0005);
    cfg_write(2'd1, 5'd29, 32'hDEAD_BEEF);
    cfg_write(2'd1, 5'd31, 32'hDEAD_BEEF);
    host_write(2'd1, 32'd2);
    repeat (3) @(negedge clk);
    cfg_read(5'd0, v); chk("R8 no alias", v, 32'hCAFE_0002);
    cfg_read(5'd29, v); chk("R8 read beyond", v, 0);

    // R2 run length, R4 zero write
    host_write(2'd0, 32'd5);
    len = 0;
    while (eng_run) begin len++; @(negedge clk); end
    chk("R2 run length", 32'(len), 5);
    host_write(2'd0, 32'd0);
    chk("R4 zero budget", 32'(eng_run), 0);

    // R3 remaining read, R4 reload ignored, R6 reject
    host_write(2'd0, 32'd10);
    host_read(2'd0, v); chk("R3 remaining", v, 9);
    host_write(2'd0, 32'd100);
    host_read(2'd0, v); chk("R4 reload ignored", v, 5);
    host_write(2'd1, 32'd3);
    chk("R6 ctx kept", 32'(eng_ctx), 2);
    chk("R6 no pulse", 32'(eng_ctx_switch), 0);
    host_read(2'd2, v); chk("R6 status run+rej", v, 32'h3);
    wait_idle();
    host_read(2'd2, v); chk("R11 run bit low", v, 32'h2);
    host_write(2'd2, 32'h2);
    host_read(2'd2, v); chk("R11 clear", v, 0);

    // R9 deferred write to active context
    host_write(2'd0, 32'd40);
    cfg_write(2'd2, 5'd0, 32'h0BAD_F00D);
    cfg_read(5'd0, v); chk("R9 old word served", v, 32'hCAFE_0002);
    host_read(2'd2, v); chk("R9 pending", v, 32'h9);
    wait_idle();
    repeat (3) @(negedge clk);
    cfg_read(5'd0, v); chk("R9 applied after run", v, 32'h0BAD_F00D);
    host_read(2'd2, v); chk("R9 drained", v, 0);

    // R10 hold queue overflow
    host_write(2'd0, 32'd100);
    for (int k = 1; k <= 5; k++) cfg_write(2'd2, 5'(k), 32'h7700_0000 | 32'(k));
    host_read(2'd2, v); chk("R10 drop flagged", v, 32'hD);
    wait_idle();
    repeat (8) @(negedge clk);
    for (int k = 1; k <= 4; k++) begin
      cfg_read(5'(k), v); chk("R10 held words", v, 32'h7700_0000 | 32'(k));
    end
    cfg_read(5'd5, v); chk("R10 dropped word", v, 32'h5555_0005);
    host_read(2'd2, v); chk("R10 sticky", v, 32'h4);
    host_write(2'd2, 32'h4);
    host_read(2'd2, v); chk("R11 drop cleared", v, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule